// File: doc/BRIEF.md
# Program/Erase Status Read Generator

This block builds the byte handed back on a read of the array while an embedded write operation (byte program or erase) is running. Software polls it to learn when the operation is over. Two status bits are available while busy. The poll bit (bit 7) returns the inverse of what the location will finally hold: the inverted bit 7 of the byte being programmed, or 0 during an erase because erased cells read as 1. The toggle bit (bit 6) changes value once for each completed read. All other bits read as 0 while busy.

When the busy flag drops, the block passes the true array byte straight through on every bit, so bit 6 stops changing. The toggle state is held at 0 whenever no operation is running. Every new operation therefore starts with a first read of 0 on bit 6, whatever reads were made before it.

The command decoder drives the busy flag, the operation type and the byte being programmed, and holds them steady for the whole operation. The array supplies the true data, and the bus interface supplies a read strobe that stays high for the length of each read. The read path has no handshake: the output byte is always valid, and a read is counted when the strobe is released.

Top module: `poll_status_gen`

## Requirements
- R1: Out of reset the toggle state is 0 and the released-strobe detector is clear, so the first read of the first operation returns 0 on bit 6.
- R2: While busy with a program (`erase_op_i` = 0), bit 7 of `rd_byte_o` is the inverse of bit 7 of `load_byte_i`.
- R3: While busy with an erase (`erase_op_i` = 1), bit 7 of `rd_byte_o` is 0.
- R4: Bit 6 reads 0 on the first read of every operation, including an operation that follows one ending with bit 6 at 1.
- R5: While busy, each read flips bit 6. A read is a high period of `rd_strobe_i` followed by a low. The new value appears after the first rising clock edge that samples the strobe low.
- R6: Bit 6 does not change on clocks with no strobe release: not on idle clocks, and not while the strobe is held high.
- R7: While busy, bits 5 down to 0 of `rd_byte_o` are 0.
- R8: While not busy, `rd_byte_o` equals `array_byte_i` on all bits in the same cycle, with no register delay.
- R9: Reads made while not busy leave no trace in the toggle bit of the next operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| busy_i | input | 1 | High while a program or erase is running |
| erase_op_i | input | 1 | Operation type: 0 program, 1 erase; held while busy |
| load_byte_i | input | 8 | Byte being programmed; held while busy |
| rd_strobe_i | input | 1 | High for the length of one read access |
| array_byte_i | input | 8 | True array contents at the read address |
| rd_byte_o | output | 8 | Byte returned to the reader |

## Verification
The data-path results are combinational and due in the same cycle as their inputs. These are bit 7, the zeroed low bits and the pass-through when idle (R2, R3, R7, R8). The bench drives on the falling clock edge and samples one nanosecond later. The toggle result is due after one rising edge: the edge that first samples the strobe low. The bench therefore lowers the strobe on a falling edge, lets one rising edge pass, and samples bit 6 during the next read. Hold and idle tests span many clocks to show that no edge other than a release moves the bit.

// File: rtl/poll_status_pkg.sv
package poll_status_pkg;

  // Operating mode of the status read path
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PROG  = 2'd1,
    ST_ERASE = 2'd2
  } stat_mode_e;

  function automatic stat_mode_e decode_mode(input logic busy, input logic erase);
    if (!busy)      return ST_IDLE;
    else if (erase) return ST_ERASE;
    else            return ST_PROG;
  endfunction

endpackage

// File: rtl/ps_edge_det.sv
module ps_edge_det #(
  parameter bit FALLING = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_i,
  output logic pulse_o
);
  logic sig_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sig_q <= 1'b0;
    else        sig_q <= sig_i;
  end

  generate
    if (FALLING) begin : g_fall
      assign pulse_o = sig_q & ~sig_i;
    end else begin : g_rise
      assign pulse_o = ~sig_q & sig_i;
    end
  endgenerate

  // R1
  rst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !sig_q);

endmodule

// File: rtl/ps_toggle.sv
module ps_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic busy_i,
  input  logic adv_i,
  output logic tgl_o
);
  logic tgl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       tgl_q <= 1'b0;
    else if (!busy_i) tgl_q <= 1'b0;
    else if (adv_i)   tgl_q <= ~tgl_q;
  end

  assign tgl_o = tgl_q;

  // R5
  tgl_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy_i) && $past(adv_i)) |-> (tgl_q != $past(tgl_q)));

  // R6
  tgl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy_i) && !$past(adv_i)) |-> $stable(tgl_q));

  // R4
  tgl_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(busy_i) |-> (tgl_q == 1'b0));

endmodule

// File: rtl/ps_out_mux.sv
module ps_out_mux
  import poll_status_pkg::*;
#(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned POLL_BIT = 7,
  parameter int unsigned TGL_BIT  = 6
) (
  input  stat_mode_e        mode_i,
  input  logic              tgl_i,
  input  logic [DATA_W-1:0] load_i,
  input  logic [DATA_W-1:0] array_i,
  output logic [DATA_W-1:0] data_o
);
  always_comb begin
    data_o = '0;
    unique case (mode_i)
      ST_PROG: begin
        data_o[POLL_BIT] = ~load_i[POLL_BIT];
        data_o[TGL_BIT]  = tgl_i;
      end
      ST_ERASE: begin
        data_o[POLL_BIT] = 1'b0;
        data_o[TGL_BIT]  = tgl_i;
      end
      default: data_o = array_i;
    endcase
  end
endmodule

// File: rtl/poll_status_gen.sv
module poll_status_gen
  import poll_status_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy_i,
  input  logic              erase_op_i,
  input  logic [DATA_W-1:0] load_byte_i,
  input  logic              rd_strobe_i,
  input  logic [DATA_W-1:0] array_byte_i,
  output logic [DATA_W-1:0] rd_byte_o
);
  localparam int unsigned POLL_BIT = DATA_W - 1;
  localparam int unsigned TGL_BIT  = DATA_W - 2;
  localparam logic [DATA_W-1:0] LOW_MASK = {2'b00, {(DATA_W-2){1'b1}}};

  logic       rd_release;
  logic       tgl;
  stat_mode_e mode;

  assign mode = decode_mode(busy_i, erase_op_i);

  ps_edge_det #(.FALLING(1'b1)) u_rd_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .sig_i  (rd_strobe_i),
    .pulse_o(rd_release)
  );

  ps_toggle u_tgl (
    .clk   (clk),
    .rst_n (rst_n),
    .busy_i(busy_i),
    .adv_i (rd_release),
    .tgl_o (tgl)
  );

  ps_out_mux #(
    .DATA_W  (DATA_W),
    .POLL_BIT(POLL_BIT),
    .TGL_BIT (TGL_BIT)
  ) u_mux (
    .mode_i (mode),
    .tgl_i  (tgl),
    .load_i (load_byte_i),
    .array_i(array_byte_i),
    .data_o (rd_byte_o)
  );

  // R2
  prog_poll_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && !erase_op_i) |-> (rd_byte_o[POLL_BIT] != load_byte_i[POLL_BIT]));

  // R3
  erase_poll_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && erase_op_i) |-> !rd_byte_o[POLL_BIT]);

  // R7
  low_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |-> ((rd_byte_o & LOW_MASK) == '0));

  // R8
  idle_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_i |-> (rd_byte_o == array_byte_i));

endmodule

// File: tb/poll_status_gen_bench.sv
module poll_status_gen_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       busy = 1'b0;
  logic       erase = 1'b0;
  logic [7:0] load = 8'h00;
  logic       strobe = 1'b0;
  logic [7:0] arr = 8'h00;
  logic [7:0] dout;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  poll_status_gen u_poll_status_gen (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy_i      (busy),
    .erase_op_i  (erase),
    .load_byte_i (load),
    .rd_strobe_i (strobe),
    .array_byte_i(arr),
    .rd_byte_o   (dout)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  // One read: strobe high for a cycle, sample, then release.
  task automatic read_once(output logic [7:0] v);
    @(negedge clk); strobe = 1'b1;
    @(negedge clk); #1 v = dout;
    strobe = 1'b0;
    @(negedge clk);
  endtask

  function automatic logic [7:0] busy_exp(input logic er, input logic [7:0] ld, input logic t);
    return {er ? 1'b0 : ~ld[7], t, 6'b0};
  endfunction

  task automatic start_op(input logic er, input logic [7:0] ld);
    @(negedge clk); busy = 1'b1; erase = er; load = ld;
  endtask

  task automatic end_op();
    @(negedge clk); busy = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk); arr = 8'hA5; #1;
    chk("R1/R8 reset passthrough", dout, 8'hA5);
  endtask

  task automatic t_program(input logic [7:0] ld);
    logic [7:0] v;
    logic t = 1'b0;
    start_op(1'b0, ld); #1;
    chk("R2/R7 program no read yet", dout, busy_exp(1'b0, ld, 1'b0));
    for (int i = 0; i < 4; i++) begin
      read_once(v);
      chk(i == 0 ? "R4 program first read" : "R5 program toggle", v, busy_exp(1'b0, ld, t));
      t = ~t;
    end
    end_op();
  endtask

  task automatic t_erase();
    logic [7:0] v;
    logic t = 1'b0;
    start_op(1'b1, 8'h7F);
    for (int i = 0; i < 3; i++) begin
      read_once(v);
      chk("R3/R5 erase read", v, busy_exp(1'b1, 8'h7F, t));
      t = ~t;
    end
    // t is 1 here; finish with bit 6 at 1
    end_op(); #1;
    arr = 8'h5A; #0.5;
    chk("R8 after erase done", dout, 8'h5A);
  endtask

  task automatic t_hold();
    logic [7:0] v;
    start_op(1'b0, 8'h00);
    repeat (10) @(negedge clk);
    #1 chk("R6 idle clocks no flip", dout, 8'h80);
    strobe = 1'b1;
    repeat (10) @(negedge clk);
    #1 chk("R6 held strobe no flip", dout, 8'h80);
    strobe = 1'b0;
    @(negedge clk); #1;
    chk("R5 flip after release", dout, 8'hC0);
    repeat (8) @(negedge clk);
    #1 chk("R6 stable after flip", dout, 8'hC0);
    end_op(); #1;
    arr = 8'hFF; #0.5;
    chk("R8 true data all ones", dout, 8'hFF);
  endtask

  task automatic t_idle_reads();
    logic [7:0] v;
    arr = 8'h3C;
    for (int i = 0; i < 3; i++) begin
      read_once(v);
      chk("R8 idle read", v, 8'h3C);
    end
    start_op(1'b0, 8'h80);
    read_once(v);
    chk("R9 first read after idle reads", v, 8'h00);
    read_once(v);
    chk("R5 second read", v, 8'h40);
    end_op();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_program(8'h3C);
    t_program(8'hC3);
    t_erase();
    t_program(8'h12); // R4: follows an op that ended with bit 6 high
    t_hold();
    t_idle_reads();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule